// File: doc/BRIEF.md
# Split-Nibble Arithmetic Logic Unit

This block is an 8-bit arithmetic logic unit built from two identical 4-bit slices. A small decoder turns a 4-bit operation code into slice controls. The slices then compute the byte together. Carry moves upward, from the low slice to the high slice, for additions, subtractions and left shifts. For right shifts the moving bit goes downward, from the high slice to the low slice. The zero indication is chained: the low slice reports whether its nibble is zero, and the high slice combines that with its own nibble to give the byte's zero flag. When the decimal input is set, add-with-carry and subtract-with-borrow apply a per-nibble decimal correction.

The ALU is purely combinational, except for one flip-flop. That flip-flop records the carry produced while a program-address low byte is stepped. The carry is held apart from the architectural carry, so a sequencer can later decide whether the high byte needs stepping too. The block also drives a branch-sign output: the top bit of the second operand. For a relative branch, this bit tells whether the high address byte may need to go down.

Top module: `split_nibble_alu`

## Requirements
- R1: Code 0x0 (add with carry), with `dec_mode`=0, gives `result` = (a + b + `carry_in`) mod 256. `c_out` is bit 8 of that sum. `v_out` is 1 when a and b have the same sign bit and `result` has the other sign.
- R2: Code 0x1 (subtract with borrow), with `dec_mode`=0, gives `result` = a − b − (1 − `carry_in`) mod 256. `c_out` is 1 when no borrow occurs. `v_out` is 1 when a and b differ in sign bit and `result` differs in sign from a.
- R3: For every code except 0x2 and 0x6, `z_out` is 1 exactly when `result` is 0x00, and `n_out` equals `result` bit 7.
- R4: With `dec_mode`=1 and both operands valid packed decimal, codes 0x0 and 0x1 give the packed-decimal sum or difference. `c_out` is the decimal carry (for 0x0) or the no-borrow indication (for 0x1). `v_out` is 0, and `z_out` and `n_out` follow the corrected `result`.
- R5: Code 0x2 (compare) leaves `result` equal to a. It sets `c_out` = (a ≥ b), `z_out` = (a = b), and `n_out` = bit 7 of (a − b). `v_out` is 0. Neither `dec_mode` nor `carry_in` changes any output.
- R6: Codes 0x3, 0x4 and 0x5 give a AND b, a OR b and a XOR b. Code 0x6 (bit test) keeps `result` = a, sets `z_out` = ((a AND b) = 0), `n_out` = b bit 7 and `v_out` = b bit 6. For all four codes `c_out` equals `carry_in`, and for 0x3 to 0x5 `v_out` is 0.
- R7: Code 0x7 gives a + 1, with `c_out` = 1 only when a is 0xFF. Code 0x8 gives a − 1, with `c_out` = 0 only when a is 0x00. Both ignore `dec_mode` and `carry_in`, and `v_out` is 0.
- R8: Code 0x9 shifts a left, filling bit 0 with 0. Code 0xB does the same but fills bit 0 with `carry_in`. For both, `c_out` is the old bit 7 and `v_out` is 0.
- R9: Code 0xA shifts a right, filling bit 7 with 0. Code 0xC does the same but fills bit 7 with `carry_in`. For both, `c_out` is the old bit 0 and `v_out` is 0.
- R10: Codes 0xD to 0xF pass a to `result`, set `c_out` = `carry_in` and `v_out` = 0.
- R11: On a rising `clk` edge with `addr_cap`=1, `addr_carry` loads the current `c_out`. With `addr_cap`=0 it holds its value. A synchronous `rst` clears it to 0.
- R12: `branch_sign` always equals bit 7 of b, whatever the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address-carry flip-flop |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| dec_mode | input | 1 | Decimal arithmetic enable |
| carry_in | input | 1 | Incoming carry flag |
| addr_cap | input | 1 | Load the current carry into `addr_carry` |
| result | output | 8 | Operation result |
| c_out | output | 1 | Carry / no-borrow / shifted-out bit |
| z_out | output | 1 | Zero flag |
| n_out | output | 1 | Negative flag |
| v_out | output | 1 | Overflow flag |
| addr_carry | output | 1 | Held address-step carry |
| branch_sign | output | 1 | Sign bit of the second operand |

## Verification
Several corner cases are targeted directly:
- **Decimal digit boundaries.** The bench sums 99 + 01 and subtracts 00 − 01. A slice that forwards the raw binary carry, or that skips the −6 fix on a borrow, returns 9A or FF instead of 00 or 99.
- **Right shifts.** A wrong slice pairing makes bit 4 vanish from the low nibble, or lets `carry_in` land in bit 3 instead of bit 7.
- **Byte wrap of increment and decrement.** The bench steps FF to 00 and 00 to FF and checks the carry the address latch later records.
- **Zero and sign from sub-results.** For compare and bit test, the bench checks that `z_out` and `n_out` are taken from the difference or the AND, not from the returned operand.

// File: rtl/split_alu_pkg.sv
package split_alu_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int BCD_MAX = 9;

    typedef enum logic [3:0] {
        OP_ADC = 4'h0, OP_SBC = 4'h1, OP_CMP = 4'h2, OP_AND = 4'h3,
        OP_ORA = 4'h4, OP_EOR = 4'h5, OP_BIT = 4'h6, OP_INC = 4'h7,
        OP_DEC = 4'h8, OP_ASL = 4'h9, OP_LSR = 4'hA, OP_ROL = 4'hB,
        OP_ROR = 4'hC, OP_SPD = 4'hD, OP_SPE = 4'hE, OP_SPF = 4'hF
    } alu_op_e;

    typedef enum logic [2:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SHL, K_SHR, K_PASS
    } slice_kind_e;

    typedef enum logic [1:0] { CS_UP, CS_DN, CS_IN } carry_sel_e;
    typedef enum logic [1:0] { VS_ZERO, VS_SUM, VS_B6 } ovf_sel_e;

    typedef struct packed {
        slice_kind_e         kind;
        logic                bcd;
        logic [BYTE_W-1:0]   opnd;
        logic                chain_in;
        logic                keep_a;
        logic                n_from_b;
        carry_sel_e          csel;
        ovf_sel_e            vsel;
    } alu_ctrl_t;

    function automatic logic [NIB_W:0] dec_fix_add(input logic [NIB_W:0] s);
        logic [NIB_W:0] t;
        if (s > (NIB_W+1)'(BCD_MAX)) begin
            t = s + (NIB_W+1)'(6);
            return {1'b1, t[NIB_W-1:0]};
        end
        return {1'b0, s[NIB_W-1:0]};
    endfunction

    function automatic logic [NIB_W:0] dec_fix_sub(input logic [NIB_W:0] d);
        if (d[NIB_W])
            return d;
        return {1'b0, d[NIB_W-1:0] - NIB_W'(6)};
    endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import split_alu_pkg::*;
(
    input  logic [3:0]        op_code,
    input  logic [BYTE_W-1:0] opb,
    input  logic              dec_mode,
    input  logic              carry_in,
    output alu_ctrl_t         ctrl
);
    always_comb begin
        ctrl          = '0;
        ctrl.kind     = K_PASS;
        ctrl.opnd     = opb;
        ctrl.chain_in = carry_in;
        ctrl.csel     = CS_IN;
        ctrl.vsel     = VS_ZERO;
        case (alu_op_e'(op_code))
            OP_ADC, OP_SBC: begin
                ctrl.kind = (alu_op_e'(op_code) == OP_ADC) ? K_ADD : K_SUB;
                ctrl.bcd  = dec_mode;
                ctrl.csel = CS_UP;
                ctrl.vsel = dec_mode ? VS_ZERO : VS_SUM;
            end
            OP_CMP: begin
                ctrl.kind     = K_SUB;
                ctrl.chain_in = 1'b1;
                ctrl.keep_a   = 1'b1;
                ctrl.csel     = CS_UP;
            end
            OP_AND: ctrl.kind = K_AND;
            OP_ORA: ctrl.kind = K_OR;
            OP_EOR: ctrl.kind = K_XOR;
            OP_BIT: begin
                ctrl.kind     = K_AND;
                ctrl.keep_a   = 1'b1;
                ctrl.n_from_b = 1'b1;
                ctrl.vsel     = VS_B6;
            end
            OP_INC: begin
                ctrl.kind     = K_ADD;
                ctrl.opnd     = '0;
                ctrl.chain_in = 1'b1;
                ctrl.csel     = CS_UP;
            end
            OP_DEC: begin
                ctrl.kind     = K_ADD;
                ctrl.opnd     = '1;
                ctrl.chain_in = 1'b0;
                ctrl.csel     = CS_UP;
            end
            OP_ASL, OP_ROL: begin
                ctrl.kind     = K_SHL;
                ctrl.chain_in = (alu_op_e'(op_code) == OP_ROL) ? carry_in : 1'b0;
                ctrl.csel     = CS_UP;
            end
            OP_LSR, OP_ROR: begin
                ctrl.kind     = K_SHR;
                ctrl.chain_in = (alu_op_e'(op_code) == OP_ROR) ? carry_in : 1'b0;
                ctrl.csel     = CS_DN;
            end
            default: ctrl.keep_a = 1'b1;
        endcase
    end
endmodule

// File: rtl/nib_slice.sv
module nib_slice
    import split_alu_pkg::*;
(
    input  slice_kind_e       kind,
    input  logic              bcd,
    input  logic [NIB_W-1:0]  a,
    input  logic [NIB_W-1:0]  b,
    input  logic              cin_up,
    input  logic              cin_dn,
    input  logic              zero_in,
    output logic [NIB_W-1:0]  y,
    output logic              c_up,
    output logic              c_dn,
    output logic              zero_out
);
    logic [NIB_W-1:0] bx;
    logic [NIB_W:0]   raw;
    logic [NIB_W:0]   fixed;

    // bit leaving toward the lower slice on a right shift
    assign c_dn = a[0];

    always_comb begin
        bx    = (kind == K_SUB) ? ~b : b;
        raw   = {1'b0, a} + {1'b0, bx} + {{NIB_W{1'b0}}, cin_up};
        fixed = raw;
        if (bcd)
            fixed = (kind == K_SUB) ? dec_fix_sub(raw) : dec_fix_add(raw);
        y    = a;
        c_up = 1'b0;
        case (kind)
            K_ADD, K_SUB: begin
                y    = fixed[NIB_W-1:0];
                c_up = fixed[NIB_W];
            end
            K_AND: y = a & b;
            K_OR:  y = a | b;
            K_XOR: y = a ^ b;
            K_SHL: begin
                y    = {a[NIB_W-2:0], cin_up};
                c_up = a[NIB_W-1];
            end
            K_SHR: y = {cin_dn, a[NIB_W-1:1]};
            default: y = a;
        endcase
        zero_out = zero_in && (y == '0);
    end
endmodule

// File: rtl/split_nibble_alu.sv
module split_nibble_alu
    import split_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  op_code,
    input  logic [7:0]  opa,
    input  logic [7:0]  opb,
    input  logic        dec_mode,
    input  logic        carry_in,
    input  logic        addr_cap,
    output logic [7:0]  result,
    output logic        c_out,
    output logic        z_out,
    output logic        n_out,
    output logic        v_out,
    output logic        addr_carry,
    output logic        branch_sign
);
    localparam int HI = BYTE_W - 1;

    alu_ctrl_t         ctrl;
    logic [NIB_W-1:0]  y_lo, y_hi;
    logic              lo_cup, lo_cdn, hi_cup, hi_cdn;
    logic              lo_zero, hi_zero;
    logic [BYTE_W-1:0] y_all;
    logic              bx_msb;

    alu_op_decode u_dec (
        .op_code  (op_code),
        .opb      (opb),
        .dec_mode (dec_mode),
        .carry_in (carry_in),
        .ctrl     (ctrl)
    );

    // low slice: upward chain enters here, downward chain arrives from high
    nib_slice u_lo (
        .kind     (ctrl.kind),
        .bcd      (ctrl.bcd),
        .a        (opa[NIB_W-1:0]),
        .b        (ctrl.opnd[NIB_W-1:0]),
        .cin_up   (ctrl.chain_in),
        .cin_dn   (hi_cdn),
        .zero_in  (1'b1),
        .y        (y_lo),
        .c_up     (lo_cup),
        .c_dn     (lo_cdn),
        .zero_out (lo_zero)
    );

    // high slice: upward chain arrives from low, downward chain enters here
    nib_slice u_hi (
        .kind     (ctrl.kind),
        .bcd      (ctrl.bcd),
        .a        (opa[BYTE_W-1:NIB_W]),
        .b        (ctrl.opnd[BYTE_W-1:NIB_W]),
        .cin_up   (lo_cup),
        .cin_dn   (ctrl.chain_in),
        .zero_in  (lo_zero),
        .y        (y_hi),
        .c_up     (hi_cup),
        .c_dn     (hi_cdn),
        .zero_out (hi_zero)
    );

    assign y_all       = {y_hi, y_lo};
    assign bx_msb      = (ctrl.kind == K_SUB) ? ~ctrl.opnd[HI] : ctrl.opnd[HI];
    assign result      = ctrl.keep_a ? opa : y_all;
    assign z_out       = hi_zero;
    assign n_out       = ctrl.n_from_b ? opb[HI] : y_all[HI];
    assign branch_sign = opb[HI];

    always_comb begin
        case (ctrl.csel)
            CS_UP:   c_out = hi_cup;
            CS_DN:   c_out = lo_cdn;
            default: c_out = carry_in;
        endcase
        case (ctrl.vsel)
            VS_SUM:  v_out = (opa[HI] == bx_msb) && (y_all[HI] != opa[HI]);
            VS_B6:   v_out = opb[HI-1];
            default: v_out = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_carry <= 1'b0;
        else if (addr_cap)
            addr_carry <= c_out;
    end

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        (op_code != OP_CMP && op_code != OP_BIT) |-> (z_out == (result == 8'h00))); // R3
    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_CMP) |-> (result == opa && c_out == (opa >= opb))); // R5
    AST_DEC_NO_V: assert property (@(posedge clk) disable iff (rst)
        (dec_mode && (op_code == OP_ADC || op_code == OP_SBC)) |-> !v_out); // R4
    AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_INC && opa == 8'hFF) |-> (result == 8'h00 && c_out)); // R7
    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_DEC && opa == 8'h00) |-> (result == 8'hFF && !c_out)); // R7
    AST_ASL_OUT: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_ASL) |-> (c_out == opa[7] && !result[0])); // R8
    AST_LSR_OUT: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_LSR) |-> (c_out == opa[0] && !result[7])); // R9
    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        addr_cap |=> (addr_carry == $past(c_out))); // R11
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !addr_cap |=> $stable(addr_carry)); // R11
endmodule

// File: tb/split_nibble_alu_tb_top.sv
`timescale 1ns/1ps
module split_nibble_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_code = 4'h0;
    logic [7:0] opa = 8'h00, opb = 8'h00;
    logic       dec_mode = 1'b0, carry_in = 1'b0, addr_cap = 1'b0;
    logic [7:0] result;
    logic       c_out, z_out, n_out, v_out, addr_carry, branch_sign;

    int runs = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    split_nibble_alu dut_i (
        .clk(clk), .rst(rst), .op_code(op_code), .opa(opa), .opb(opb),
        .dec_mode(dec_mode), .carry_in(carry_in), .addr_cap(addr_cap),
        .result(result), .c_out(c_out), .z_out(z_out), .n_out(n_out),
        .v_out(v_out), .addr_carry(addr_carry), .branch_sign(branch_sign)
    );

    // expected {result, c, z, n, v} from the written requirements
    function automatic logic [11:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic d, input logic c);
        logic [7:0] r, zb;
        logic co, v, nb, bl;
        int s, lo, hi;
        r = a; co = c; v = 1'b0; s = 0; zb = 8'h00; nb = 1'b0;
        case (op)
            4'h0: if (d) begin
                      lo = int'(a[3:0]) + int'(b[3:0]) + int'(c);
                      bl = (lo > 9); if (bl) lo = lo - 10;
                      hi = int'(a[7:4]) + int'(b[7:4]) + int'(bl);
                      co = (hi > 9); if (co) hi = hi - 10;
                      r = {hi[3:0], lo[3:0]};
                  end else begin
                      s = int'(a) + int'(b) + int'(c);
                      r = s[7:0]; co = s[8];
                      v = (a[7] == b[7]) && (r[7] != a[7]);
                  end
            4'h1: if (d) begin
                      lo = int'(a[3:0]) - int'(b[3:0]) - (1 - int'(c));
                      bl = (lo < 0); if (bl) lo = lo + 10;
                      hi = int'(a[7:4]) - int'(b[7:4]) - int'(bl);
                      co = !(hi < 0); if (hi < 0) hi = hi + 10;
                      r = {hi[3:0], lo[3:0]};
                  end else begin
                      s = int'(a) - int'(b) - (1 - int'(c));
                      r = s[7:0]; co = (s >= 0);
                      v = (a[7] != b[7]) && (r[7] != a[7]);
                  end
            4'h2: begin s = int'(a) - int'(b); co = (s >= 0); end
            4'h3: r = a & b;
            4'h4: r = a | b;
            4'h5: r = a ^ b;
            4'h6: v = b[6];
            4'h7: begin s = int'(a) + 1; r = s[7:0]; co = s[8]; end
            4'h8: begin s = int'(a) - 1; r = s[7:0]; co = (a != 8'h00); end
            4'h9: begin r = {a[6:0], 1'b0}; co = a[7]; end
            4'hA: begin r = {1'b0, a[7:1]}; co = a[0]; end
            4'hB: begin r = {a[6:0], c}; co = a[7]; end
            4'hC: begin r = {c, a[7:1]}; co = a[0]; end
            default: r = a;
        endcase
        if (op == 4'h2)      begin zb = s[7:0]; nb = zb[7]; end
        else if (op == 4'h6) begin zb = a & b;  nb = b[7];  end
        else                 begin zb = r;      nb = r[7];  end
        return {r, co, (zb == 8'h00), nb, v};
    endfunction

    task automatic check_op(input string req, input logic [3:0] op, input logic [7:0] a,
                            input logic [7:0] b, input logic d, input logic c);
        logic [11:0] exp, act;
        @(negedge clk);
        op_code = op; opa = a; opb = b; dec_mode = d; carry_in = c;
        #1;
        exp = model(op, a, b, d, c);
        act = {result, c_out, z_out, n_out, v_out};
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%h a=%h b=%h d=%b c=%b actual={r,c,z,n,v}=%h expected=%h",
                     req, op, a, b, d, c, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rnd_bcd();
        logic [3:0] h, l;
        h = 4'($urandom % 10); l = 4'($urandom % 10);
        return {h, l};
    endfunction

    task automatic t_reset();
        #1;
        check_bit("R11 reset", addr_carry, 1'b0);
    endtask

    task automatic t_adc_bin();
        check_op("R1", 4'h0, 8'h7F, 8'h01, 1'b0, 1'b0);
        check_op("R1", 4'h0, 8'hFF, 8'h01, 1'b0, 1'b0);
        check_op("R1", 4'h0, 8'hFF, 8'hFF, 1'b0, 1'b1);
        for (int i = 0; i < 60; i++)
            check_op("R1", 4'h0, 8'($urandom), 8'($urandom), 1'b0, 1'($urandom));
    endtask

    task automatic t_sbc_bin();
        check_op("R2", 4'h1, 8'h80, 8'h01, 1'b0, 1'b1);
        check_op("R2", 4'h1, 8'h00, 8'h01, 1'b0, 1'b1);
        check_op("R2", 4'h1, 8'h05, 8'h05, 1'b0, 1'b0);
        for (int i = 0; i < 60; i++)
            check_op("R2", 4'h1, 8'($urandom), 8'($urandom), 1'b0, 1'($urandom));
    endtask

    task automatic t_zero();
        check_op("R3", 4'h0, 8'h80, 8'h80, 1'b0, 1'b0);
        check_op("R3", 4'h1, 8'h42, 8'h42, 1'b0, 1'b1);
        check_op("R3", 4'h5, 8'hA5, 8'hA5, 1'b0, 1'b0);
    endtask

    task automatic t_decimal();
        check_op("R4", 4'h0, 8'h99, 8'h01, 1'b1, 1'b0);
        check_op("R4", 4'h0, 8'h45, 8'h45, 1'b1, 1'b1);
        check_op("R4", 4'h1, 8'h00, 8'h01, 1'b1, 1'b1);
        check_op("R4", 4'h1, 8'h50, 8'h50, 1'b1, 1'b1);
        for (int i = 0; i < 60; i++) begin
            check_op("R4", 4'h0, rnd_bcd(), rnd_bcd(), 1'b1, 1'($urandom));
            check_op("R4", 4'h1, rnd_bcd(), rnd_bcd(), 1'b1, 1'($urandom));
        end
    endtask

    task automatic t_cmp();
        check_op("R5", 4'h2, 8'h40, 8'h40, 1'b1, 1'b0);
        check_op("R5", 4'h2, 8'h10, 8'h20, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++)
            check_op("R5", 4'h2, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    endtask

    task automatic t_logic();
        check_op("R6", 4'h6, 8'h0F, 8'hF0, 1'b0, 1'b1);
        check_op("R6", 4'h6, 8'hFF, 8'h40, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) begin
            check_op("R6", 4'h3, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
            check_op("R6", 4'h4, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
            check_op("R6", 4'h5, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
            check_op("R6", 4'h6, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    task automatic t_incdec();
        check_op("R7", 4'h7, 8'hFF, 8'h12, 1'b1, 1'b1);
        check_op("R7", 4'h7, 8'h7F, 8'h00, 1'b0, 1'b0);
        check_op("R7", 4'h8, 8'h00, 8'h34, 1'b1, 1'b1);
        check_op("R7", 4'h8, 8'h10, 8'h00, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) begin
            check_op("R7", 4'h7, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
            check_op("R7", 4'h8, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    task automatic t_left();
        check_op("R8", 4'h9, 8'h88, 8'h00, 1'b0, 1'b1);
        check_op("R8", 4'hB, 8'h08, 8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 30; i++) begin
            check_op("R8", 4'h9, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
            check_op("R8", 4'hB, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    task automatic t_right();
        check_op("R9", 4'hA, 8'h11, 8'h00, 1'b0, 1'b1);
        check_op("R9", 4'hC, 8'h10, 8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 30; i++) begin
            check_op("R9", 4'hA, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
            check_op("R9", 4'hC, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    task automatic t_spare();
        for (int k = 13; k < 16; k++) begin
            check_op("R10", 4'(k), 8'h00, 8'hFF, 1'b1, 1'b1);
            check_op("R10", 4'(k), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    task automatic t_addr_latch();
        @(negedge clk);
        op_code = 4'h7; opa = 8'hFF; opb = 8'h00; dec_mode = 1'b0; carry_in = 1'b0; addr_cap = 1'b1;
        @(posedge clk); #1;
        check_bit("R11 load carry", addr_carry, 1'b1);
        @(negedge clk);
        opa = 8'h10; addr_cap = 1'b0;
        @(posedge clk); #1;
        check_bit("R11 hold", addr_carry, 1'b1);
        @(negedge clk);
        addr_cap = 1'b1;
        @(posedge clk); #1;
        check_bit("R11 load no carry", addr_carry, 1'b0);
        @(negedge clk);
        op_code = 4'h0; opa = 8'hF0; opb = 8'h20;
        @(posedge clk); #1;
        check_bit("R11 load add carry", addr_carry, 1'b1);
        @(negedge clk);
        addr_cap = 1'b0; rst = 1'b1;
        @(posedge clk); #1;
        check_bit("R11 reset clear", addr_carry, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_branch();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            op_code = 4'(i); opa = 8'($urandom); opb = 8'($urandom);
            dec_mode = 1'($urandom); carry_in = 1'($urandom);
            #1;
            check_bit("R12 branch sign", branch_sign, opb[7]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_adc_bin();
        t_sbc_bin();
        t_zero();
        t_decimal();
        t_cmp();
        t_logic();
        t_incdec();
        t_left();
        t_right();
        t_spare();
        t_addr_latch();
        t_branch();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            runs++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

endmodule